// File: doc/BRIEF.md
# Direct-Mapped Cache Line Storage with Fill Forwarding

This block holds the data half of a direct-mapped cache: a set of lines, each one block of four 32-bit words, addressed by a line index. A cache controller outside the block decides hits and misses. It drives two write strobes into this block. The fill strobe loads a whole block returned by main memory into the indexed line. The store strobe overwrites one word of that line with data from the processor.

The load data output is always the word that the offset chooses. Outside a fill it comes from the stored line. During a fill it comes from the block arriving on the fill bus, so the stalled load completes in the same cycle as the refill. Reads are purely combinational from index and offset. Writes take effect on the rising clock edge. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `dcache_data_array`

## Requirements
- R1: After reset, every word of every line reads as zero.
- R2: With no fill active, load_data shows the word of line `line_idx` chosen by `byte_ofs[3:2]`, combinationally and within the same cycle. Word k of a block occupies bits [32k+31:32k].
- R3: Bits [1:0] of byte_ofs have no effect on load_data.
- R4: A rising edge with fill_en high stores the whole of fill_data into line `line_idx`, with word k taken from bits [32k+31:32k]. All other lines keep their contents.
- R5: While fill_en is high, load_data equals the word of fill_data chosen by `byte_ofs[3:2]`, whatever the line currently holds.
- R6: A rising edge with store_en high and fill_en low replaces only the word `byte_ofs[3:2]` of line `line_idx` with store_data. The other three words of that line and all other lines are unchanged.
- R7: When fill_en and store_en are high together, the fill is performed and store_data is discarded.
- R8: When neither strobe is high, no stored word changes, and load_data stays constant while line_idx and byte_ofs[3:2] stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| line_idx | input | 4 | Selects the cache line |
| byte_ofs | input | 4 | Byte offset within the block; bits [3:2] pick the word |
| fill_en | input | 1 | Load the whole fill block into the indexed line |
| store_en | input | 1 | Overwrite the selected word with store_data |
| fill_data | input | 128 | Block arriving from main memory |
| store_data | input | 32 | Word written by the processor |
| load_data | output | 32 | Selected word, forwarded from fill_data during a fill |

## Verification
Reads and fill forwarding are due in the same cycle as the inputs that cause them, so the bench drives every input at the falling edge and compares load_data one nanosecond later, before any rising edge intervenes. Stored effects of a fill or a store are due after the next rising edge. The bench model is updated only after that edge, and the effect is first compared in the following falling-edge window. Reset release passes through two synchronizer flops, so the bench waits three edges after deasserting rst_n before it issues the first write.

// File: rtl/dca_pkg.sv
`timescale 1ns/1ps
package dca_pkg;

  // Write operation chosen for the current cycle.
  typedef enum logic [1:0] {
    DCA_IDLE  = 2'd0,
    DCA_FILL  = 2'd1,
    DCA_PATCH = 2'd2
  } dca_op_e;

endpackage

// File: rtl/dca_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assertion, synchronous release of the block reset.
module dca_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic stage1_q;
  logic stage1_d;
  logic stage2_d;

  always_comb begin
    stage1_d = 1'b1;
    stage2_d = stage1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      stage1_q <= stage1_d;
      rst_q_n  <= stage2_d;
    end
  end

endmodule

// File: rtl/dca_wr_ctrl.sv
`timescale 1ns/1ps
// Decodes the two write strobes into line and word enables; fill wins.
module dca_wr_ctrl
  import dca_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int IDX_W  = $clog2(LINES),
  parameter int SEL_W  = $clog2(WORDS),
  parameter int BLK_W  = WORD_W * WORDS
) (
  input  logic              refill_en,
  input  logic              update_en,
  input  logic [IDX_W-1:0]  line_idx,
  input  logic [SEL_W-1:0]  word_sel,
  input  logic [BLK_W-1:0]  fill_data,
  input  logic [WORD_W-1:0] store_data,
  output logic [LINES-1:0]  line_we,
  output logic [WORDS-1:0]  word_we,
  output logic [BLK_W-1:0]  word_d
);

  dca_op_e op;

  always_comb begin
    if (refill_en)      op = DCA_FILL;
    else if (update_en) op = DCA_PATCH;
    else                op = DCA_IDLE;
  end

  always_comb begin
    line_we = '0;
    word_we = '0;
    case (op)
      DCA_FILL: begin
        line_we[line_idx] = 1'b1;
        word_we           = '1;
      end
      DCA_PATCH: begin
        line_we[line_idx] = 1'b1;
        word_we[word_sel] = 1'b1;
      end
      default: begin
        line_we = '0;
        word_we = '0;
      end
    endcase
  end

  for (genvar k = 0; k < WORDS; k++) begin : g_word_d
    assign word_d[k*WORD_W +: WORD_W] =
      (op == DCA_FILL) ? fill_data[k*WORD_W +: WORD_W] : store_data;
  end

endmodule

// File: rtl/dca_line.sv
`timescale 1ns/1ps
// One cache line: WORDS independently enabled word registers.
module dca_line #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int BLK_W  = WORD_W * WORDS
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  logic             line_we,
  input  logic [WORDS-1:0] word_we,
  input  logic [BLK_W-1:0] word_d,
  output logic [BLK_W-1:0] line_q
);

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    logic [WORD_W-1:0] cur_q;
    logic [WORD_W-1:0] nxt_d;
    logic              wen;

    assign wen = line_we & word_we[k];

    always_comb begin
      if (wen) nxt_d = word_d[k*WORD_W +: WORD_W];
      else     nxt_d = cur_q;
    end

    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n) cur_q <= '0;
      else          cur_q <= nxt_d;
    end

    assign line_q[k*WORD_W +: WORD_W] = cur_q;
  end

endmodule

// File: rtl/dca_rd_mux.sv
`timescale 1ns/1ps
// Read path: line select, fill bypass, then word select.
module dca_rd_mux #(
  parameter int LINES  = 16,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int IDX_W  = $clog2(LINES),
  parameter int SEL_W  = $clog2(WORDS),
  parameter int BLK_W  = WORD_W * WORDS
) (
  input  logic [BLK_W-1:0]  line_q [LINES],
  input  logic [IDX_W-1:0]  line_idx,
  input  logic [SEL_W-1:0]  word_sel,
  input  logic              refill_en,
  input  logic [BLK_W-1:0]  fill_data,
  output logic [WORD_W-1:0] load_data
);

  logic [BLK_W-1:0]  stored_blk;
  logic [BLK_W-1:0]  src_blk;
  logic [WORD_W-1:0] words [WORDS];

  assign stored_blk = line_q[line_idx];
  assign src_blk    = refill_en ? fill_data : stored_blk;

  for (genvar k = 0; k < WORDS; k++) begin : g_split
    assign words[k] = src_blk[k*WORD_W +: WORD_W];
  end

  assign load_data = words[word_sel];

endmodule

// File: rtl/dcache_data_array.sv
`timescale 1ns/1ps
// Top: data storage of a direct-mapped cache with fill forwarding.
module dcache_data_array #(
  parameter  int LINES  = 16,
  parameter  int WORD_W = 32,
  parameter  int WORDS  = 4,
  localparam int IDX_W  = $clog2(LINES),
  localparam int SEL_W  = $clog2(WORDS),
  localparam int BYTE_W = $clog2(WORD_W / 8),
  localparam int OFS_W  = SEL_W + BYTE_W,
  localparam int BLK_W  = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  line_idx,
  input  logic [OFS_W-1:0]  byte_ofs,
  input  logic              fill_en,
  input  logic              store_en,
  input  logic [BLK_W-1:0]  fill_data,
  input  logic [WORD_W-1:0] store_data,
  output logic [WORD_W-1:0] load_data
);

  logic              rst_q_n;
  logic [SEL_W-1:0]  word_sel;
  logic              unused_byte_bits;
  logic [LINES-1:0]  line_we;
  logic [WORDS-1:0]  word_we;
  logic [BLK_W-1:0]  word_d;
  logic [BLK_W-1:0]  line_q [LINES];

  assign word_sel         = byte_ofs[OFS_W-1:BYTE_W];
  assign unused_byte_bits = ^byte_ofs[BYTE_W-1:0];

  dca_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  dca_wr_ctrl #(
    .LINES(LINES), .WORD_W(WORD_W), .WORDS(WORDS),
    .IDX_W(IDX_W), .SEL_W(SEL_W), .BLK_W(BLK_W)
  ) u_wr (
    .refill_en  (fill_en),
    .update_en  (store_en),
    .line_idx   (line_idx),
    .word_sel   (word_sel),
    .fill_data  (fill_data),
    .store_data (store_data),
    .line_we    (line_we),
    .word_we    (word_we),
    .word_d     (word_d)
  );

  for (genvar l = 0; l < LINES; l++) begin : g_line
    dca_line #(
      .WORD_W(WORD_W), .WORDS(WORDS), .BLK_W(BLK_W)
    ) u_line (
      .clk     (clk),
      .rst_q_n (rst_q_n),
      .line_we (line_we[l]),
      .word_we (word_we),
      .word_d  (word_d),
      .line_q  (line_q[l])
    );
  end

  dca_rd_mux #(
    .LINES(LINES), .WORD_W(WORD_W), .WORDS(WORDS),
    .IDX_W(IDX_W), .SEL_W(SEL_W), .BLK_W(BLK_W)
  ) u_rd (
    .line_q    (line_q),
    .line_idx  (line_idx),
    .word_sel  (word_sel),
    .refill_en (fill_en),
    .fill_data (fill_data),
    .load_data (load_data)
  );

endmodule

// File: rtl/dca_data_array_chk.sv
`timescale 1ns/1ps
// Temporal checks on the data array ports.
module dca_data_array_chk #(
  parameter  int LINES  = 16,
  parameter  int WORD_W = 32,
  parameter  int WORDS  = 4,
  localparam int IDX_W  = $clog2(LINES),
  localparam int SEL_W  = $clog2(WORDS),
  localparam int BYTE_W = $clog2(WORD_W / 8),
  localparam int OFS_W  = SEL_W + BYTE_W,
  localparam int BLK_W  = WORD_W * WORDS
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic [IDX_W-1:0]  line_idx,
  input logic [OFS_W-1:0]  byte_ofs,
  input logic              fill_en,
  input logic              store_en,
  input logic [BLK_W-1:0]  fill_data,
  input logic [WORD_W-1:0] store_data,
  input logic [WORD_W-1:0] load_data
);

  logic              armed;
  logic [SEL_W-1:0]  wsel;
  logic [WORD_W-1:0] fill_word;
  logic              quiet;
  logic              unused_chk_bits;

  assign wsel            = byte_ofs[OFS_W-1:BYTE_W];
  assign unused_chk_bits = ^byte_ofs[BYTE_W-1:0];
  assign fill_word       = fill_data[wsel*WORD_W +: WORD_W];
  assign quiet           = !fill_en && !store_en;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) armed <= 1'b0;
    else          armed <= 1'b1;
  end

  // R5: fill forwarding
  p_fill_fwd_r5: assert property (@(posedge clk) disable iff (!armed)
    fill_en |-> load_data == fill_word);

  // R4: filled word is readable on the next cycle
  p_fill_store_r4: assert property (@(posedge clk) disable iff (!armed)
    fill_en ##1 (quiet && line_idx == $past(line_idx) && wsel == $past(wsel))
    |-> load_data == $past(fill_word));

  // R6: stored word is readable on the next cycle
  p_patch_store_r6: assert property (@(posedge clk) disable iff (!armed)
    (store_en && !fill_en) ##1
    (quiet && line_idx == $past(line_idx) && wsel == $past(wsel))
    |-> load_data == $past(store_data));

  // R7: fill wins over a simultaneous store
  p_fill_wins_r7: assert property (@(posedge clk) disable iff (!armed)
    (fill_en && store_en) ##1
    (quiet && line_idx == $past(line_idx) && wsel == $past(wsel))
    |-> load_data == $past(fill_word));

  // R8 and R3: idle contents hold, low offset bits are ignored
  p_hold_r8: assert property (@(posedge clk) disable iff (!armed)
    quiet ##1 (quiet && line_idx == $past(line_idx) && wsel == $past(wsel))
    |-> $stable(load_data));

endmodule

bind dcache_data_array dca_data_array_chk #(
  .LINES(LINES), .WORD_W(WORD_W), .WORDS(WORDS)
) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .line_idx   (line_idx),
  .byte_ofs   (byte_ofs),
  .fill_en    (fill_en),
  .store_en   (store_en),
  .fill_data  (fill_data),
  .store_data (store_data),
  .load_data  (load_data)
);

// File: tb/tb_dcache_data_array.sv
`timescale 1ns/1ps
module tb_dcache_data_array;

  localparam int LINES = 16;

  logic         clk;
  logic         rst_n;
  logic [3:0]   line_idx;
  logic [3:0]   byte_ofs;
  logic         fill_en;
  logic         store_en;
  logic [127:0] fill_data;
  logic [31:0]  store_data;
  logic [31:0]  load_data;

  logic [127:0] mdl [LINES];
  int checks;
  int fails;

  dcache_data_array dut (
    .clk(clk), .rst_n(rst_n), .line_idx(line_idx), .byte_ofs(byte_ofs),
    .fill_en(fill_en), .store_en(store_en), .fill_data(fill_data),
    .store_data(store_data), .load_data(load_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] pick(input logic [127:0] blk, input logic [3:0] ofs);
    return blk[ofs[3:2]*32 +: 32];
  endfunction

  function automatic logic [127:0] rnd_blk();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic check(input logic [31:0] exp, input string req);
    checks++;
    if (load_data !== exp) begin
      fails++;
      $display("FAIL %s: load_data=%h expected=%h (idx=%0d ofs=%0d)",
               req, load_data, exp, line_idx, byte_ofs);
    end
  endtask

  // One cycle: drive at falling edge, compare, then apply write to model after rising edge.
  task automatic step(input logic rf, input logic up, input int idx,
                      input logic [3:0] ofs, input logic [127:0] blk,
                      input logic [31:0] wd, input string req);
    logic [31:0] exp;
    @(negedge clk);
    fill_en = rf; store_en = up; line_idx = idx[3:0]; byte_ofs = ofs;
    fill_data = blk; store_data = wd;
    #1;
    exp = rf ? pick(blk, ofs) : pick(mdl[idx], ofs);
    check(exp, req);
    @(posedge clk);
    if (rf)      mdl[idx] = blk;
    else if (up) mdl[idx][ofs[3:2]*32 +: 32] = wd;
  endtask

  task automatic rd(input int idx, input logic [3:0] ofs, input string req);
    step(1'b0, 1'b0, idx, ofs, rnd_blk(), $urandom(), req);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [127:0] a;
    logic [127:0] b;
    logic [31:0]  w;
    void'($urandom(32'd20240601));
    checks = 0; fails = 0;
    rst_n = 1'b0; fill_en = 1'b0; store_en = 1'b0; line_idx = '0;
    byte_ofs = '0; fill_data = '0; store_data = '0;
    for (int i = 0; i < LINES; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: everything zero after reset
    for (int i = 0; i < LINES; i++)
      for (int k = 0; k < 4; k++) rd(i, 4'(k*4), "R1");

    // R5 forwarding on fill, R4 storing
    a = 128'h44444444_33333333_22222222_11111111;
    step(1'b1, 1'b0, 3, 4'd8, a, 32'h0, "R5");
    for (int k = 0; k < 4; k++) rd(3, 4'(k*4), "R2");
    // R3: low bits ignored
    for (int lo = 0; lo < 4; lo++) rd(3, 4'(8 + lo), "R3");
    rd(2, 4'd0, "R4");
    rd(4, 4'd12, "R4");

    // Boundary: last line
    b = rnd_blk();
    step(1'b1, 1'b0, LINES-1, 4'd15, b, 32'h0, "R5");
    for (int k = 0; k < 4; k++) rd(LINES-1, 4'(k*4 + 3), "R4");
    for (int k = 0; k < 4; k++) rd(3, 4'(k*4), "R4");

    // R6: single word store
    step(1'b0, 1'b1, 3, 4'd9, rnd_blk(), 32'hDEADBEEF, "R6");
    for (int k = 0; k < 4; k++) rd(3, 4'(k*4), "R6");
    rd(LINES-1, 4'd8, "R6");

    // R7: fill beats store
    b = rnd_blk();
    w = 32'hCAFEF00D;
    step(1'b1, 1'b1, 3, 4'd4, b, w, "R7");
    for (int k = 0; k < 4; k++) rd(3, 4'(k*4), "R7");

    // R8: hold while idle
    for (int n = 0; n < 6; n++) rd(3, 4'(4 + (n % 4)), "R8");

    // Random traffic
    for (int n = 0; n < 800; n++) begin
      int r;
      logic rf, up;
      r  = int'($urandom_range(0, 99));
      rf = (r < 25) || (r >= 50 && r < 60);
      up = (r >= 25 && r < 60);
      step(rf, up, int'($urandom_range(0, LINES-1)), 4'($urandom()),
           rnd_blk(), $urandom(), rf ? (up ? "R7" : "R5") : (up ? "R6" : "R2"));
    end

    // Final sweep: model and array agree
    for (int i = 0; i < LINES; i++)
      for (int k = 0; k < 4; k++) rd(i, 4'(k*4), "R8");

    finish_run();
  end

endmodule